// File: doc/BRIEF.md
# Transmit Pool Ready Signaling Logic

This block decides when the host processor of a serial frame transmitter may load the next block of frame data. The host fills a transmit pool, which holds up to 32 bytes, and then strobes a command. One command kind sends transparent frames. The other sends information frames that the remote station must acknowledge. Either kind can carry an end-of-message flag. The block watches three indications from the transmitter: a pool has drained, the whole frame has left, and the remote station has acknowledged. From these it raises a registered one-cycle ready pulse.

The moment the pulse fires depends on the command that is pending. Without the end flag, the pulse fires as soon as a pool drains while the frame is still open. With the end flag, it waits for the whole frame to go out. In automatic mode, an information frame with the end flag also waits for the positive acknowledgement. Only one command can be outstanding at a time. A second strobe that arrives while a command is pending is dropped, and a sticky error flag records it.

Top module: `tx_ready_top`

## Requirements
- R1: During and after a synchronous reset, `readyPulse` and `cmdError` are 0 and no command is pending.
- R2: `cmdType` 2'b01 is a transparent send and 2'b10 is an information send. A strobe with 2'b00 or 2'b11 is ignored: no command is latched and `cmdError` does not change.
- R3: Without the end flag (`cmdEnd`=0), the pending command completes in a cycle where `poolEmpty`=1 and `frameDone`=0. `readyPulse` is 1 in the following cycle.
- R4: For a command without the end flag, a cycle with `poolEmpty`=1 and `frameDone`=1 together does not complete it.
- R5: A transparent send with `cmdEnd`=1 completes only in a cycle with `frameDone`=1. `poolEmpty` has no effect on it. `readyPulse` follows one cycle later.
- R6: An information send with `cmdEnd`=1 and `autoMode`=1 completes once both `frameDone` and `remoteAck` have been seen since it was accepted. They may come in either order or in the same cycle. `readyPulse` follows one cycle after the later of the two.
- R7: An information send with `cmdEnd`=1 and `autoMode`=0 completes on `frameDone` alone. `autoMode` is sampled with the strobe.
- R8: Each completion gives a `readyPulse` of exactly one cycle, and the block then returns to idle.
- R9: A valid strobe that arrives while a command is pending and not completing is ignored. The pending command keeps its behaviour, and `cmdError` goes to 1 in the next cycle and stays at 1 until reset.
- R10: A valid strobe in the same cycle that the pending command completes is accepted as the new command, and `cmdError` is not set.
- R11: While idle, `poolEmpty`, `frameDone` and `remoteAck` produce no `readyPulse`.
- R12: A synchronous reset clears the pending command and `cmdError`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdType | input | 2 | Command kind: 01 transparent, 10 information |
| cmdEnd | input | 1 | End-of-message flag for the command |
| autoMode | input | 1 | Acknowledged mode, sampled with the strobe |
| poolEmpty | input | 1 | One transmit pool has drained |
| frameDone | input | 1 | The whole frame has been transmitted |
| remoteAck | input | 1 | Positive acknowledgement from the remote station |
| readyPulse | output | 1 | One-cycle pulse: the host may load the next pool |
| cmdError | output | 1 | Sticky flag: a strobe was dropped while busy |

## Verification
Two functions can fall in the same cycle: completion of the pending command, and acceptance of a new strobe. The bench provokes this by raising `poolEmpty` together with a new transparent end-of-message strobe while a no-end command is pending. It then expects a ready pulse with `cmdError` still 0. After that, a lone `poolEmpty` must give no pulse and `frameDone` must give one, which proves that the new command was latched. A second overlap, `frameDone` with `remoteAck` in one cycle, is judged by a pulse on the very next cycle.

// File: rtl/tx_ready_pkg.sv
package tx_ready_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POOL  = 2'd1,
    ST_FRAME = 2'd2,
    ST_BOTH  = 2'd3
  } txWaitState_e;

  typedef struct packed {
    logic accept;
    logic reject;
    logic complete;
    logic track;
  } txStrobes_t;

endpackage

// File: rtl/tx_ready_ctrl.sv
module tx_ready_ctrl
  import tx_ready_pkg::*;
#(
  parameter int CMD_W = 2,
  parameter logic [CMD_W-1:0] CODE_TRANS = 2'b01,
  parameter logic [CMD_W-1:0] CODE_INFO  = 2'b10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdType,
  input  logic             cmdEnd,
  input  logic             autoMode,
  input  logic             poolEmpty,
  input  logic             frameDone,
  input  logic             remoteAck,
  input  logic             seenFrame,
  input  logic             seenAck,
  output txStrobes_t       strobes,
  output txWaitState_e     waitState
);

  txWaitState_e stateQ, stateD, decoded;
  logic isTrans, isInfo, cmdKnown, completeNow, freeNow;

  assign isTrans  = (cmdType == CODE_TRANS);
  assign isInfo   = (cmdType == CODE_INFO);
  assign cmdKnown = cmdValid && (isTrans || isInfo);

  always_comb begin
    unique case (stateQ)
      ST_POOL:  completeNow = poolEmpty && !frameDone;
      ST_FRAME: completeNow = frameDone;
      ST_BOTH:  completeNow = (seenFrame || frameDone) && (seenAck || remoteAck);
      default:  completeNow = 1'b0;
    endcase
  end

  assign freeNow = (stateQ == ST_IDLE) || completeNow;

  always_comb begin
    if (!cmdEnd)                 decoded = ST_POOL;
    else if (isInfo && autoMode) decoded = ST_BOTH;
    else                         decoded = ST_FRAME;
  end

  always_comb begin
    strobes.accept   = cmdKnown && freeNow;
    strobes.reject   = cmdKnown && !freeNow;
    strobes.complete = completeNow;
    strobes.track    = (stateQ == ST_BOTH);
  end

  always_comb begin
    stateD = stateQ;
    if (strobes.accept)   stateD = decoded;
    else if (completeNow) stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign waitState = stateQ;

endmodule

// File: rtl/tx_ready_dp.sv
module tx_ready_dp
  import tx_ready_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  txStrobes_t strobes,
  input  logic       frameDone,
  input  logic       remoteAck,
  output logic       seenFrame,
  output logic       seenAck,
  output logic       readyPulse,
  output logic       cmdError
);

  always_ff @(posedge clk) begin
    if (rst) begin
      seenFrame  <= 1'b0;
      seenAck    <= 1'b0;
      readyPulse <= 1'b0;
      cmdError   <= 1'b0;
    end else begin
      readyPulse <= strobes.complete;
      if (strobes.reject) cmdError <= 1'b1;
      if (strobes.accept) begin
        seenFrame <= 1'b0;
        seenAck   <= 1'b0;
      end else if (strobes.track) begin
        if (frameDone) seenFrame <= 1'b1;
        if (remoteAck) seenAck   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tx_ready_top.sv
module tx_ready_top
  import tx_ready_pkg::*;
#(
  parameter int CMD_W = 2,
  parameter logic [CMD_W-1:0] CODE_TRANS = 2'b01,
  parameter logic [CMD_W-1:0] CODE_INFO  = 2'b10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdType,
  input  logic             cmdEnd,
  input  logic             autoMode,
  input  logic             poolEmpty,
  input  logic             frameDone,
  input  logic             remoteAck,
  output logic             readyPulse,
  output logic             cmdError
);

  txStrobes_t   ctlStrobes;
  txWaitState_e ctlState;
  logic         seenFrame, seenAck;

  tx_ready_ctrl #(
    .CMD_W(CMD_W), .CODE_TRANS(CODE_TRANS), .CODE_INFO(CODE_INFO)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdEnd(cmdEnd), .autoMode(autoMode), .poolEmpty(poolEmpty),
    .frameDone(frameDone), .remoteAck(remoteAck),
    .seenFrame(seenFrame), .seenAck(seenAck),
    .strobes(ctlStrobes), .waitState(ctlState)
  );

  tx_ready_dp u_dp (
    .clk(clk), .rst(rst), .strobes(ctlStrobes),
    .frameDone(frameDone), .remoteAck(remoteAck),
    .seenFrame(seenFrame), .seenAck(seenAck),
    .readyPulse(readyPulse), .cmdError(cmdError)
  );

endmodule

// File: rtl/tx_ready_checker.sv
module tx_ready_checker
  import tx_ready_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input logic         poolEmpty,
  input logic         frameDone,
  input logic         remoteAck,
  input logic         readyPulse,
  input logic         cmdError,
  input logic         seenAck,
  input txStrobes_t   ctlStrobes,
  input txWaitState_e ctlState
);

  // R1, R12: reset leaves both outputs low
  p_reset_quiet_r12: assert property (@(posedge clk) rst |=> (!readyPulse && !cmdError));

  // R11: no pulse follows an idle cycle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_IDLE) |=> !readyPulse);

  // R3: a drained pool on an open frame gives a pulse
  p_pool_ready_r3: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_POOL && poolEmpty && !frameDone) |=> readyPulse);

  // R4: a drain together with frame end does not complete a no-end command
  p_pool_with_frame_r4: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_POOL && frameDone) |=> !readyPulse);

  // R5: frame end completes a wait-for-frame command
  p_frame_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_FRAME && frameDone) |=> readyPulse);

  // R6: no pulse before an acknowledgement
  p_wait_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_BOTH && !remoteAck && !seenAck) |=> !readyPulse);

  // R9: a rejected strobe raises the error flag
  p_reject_err_r9: assert property (@(posedge clk) disable iff (rst)
    ctlStrobes.reject |=> cmdError);

  // R9: the error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    cmdError |=> cmdError);

endmodule

bind tx_ready_top tx_ready_checker u_chk (
  .clk(clk), .rst(rst), .poolEmpty(poolEmpty), .frameDone(frameDone),
  .remoteAck(remoteAck), .readyPulse(readyPulse), .cmdError(cmdError),
  .seenAck(seenAck), .ctlStrobes(ctlStrobes), .ctlState(ctlState)
);

// File: tb/sim_tx_ready_top.sv
module sim_tx_ready_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdType = 2'b00;
  logic       cmdEnd = 1'b0;
  logic       autoMode = 1'b0;
  logic       poolEmpty = 1'b0;
  logic       frameDone = 1'b0;
  logic       remoteAck = 1'b0;
  logic       readyPulse, cmdError;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_ready_top u0 (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdEnd(cmdEnd), .autoMode(autoMode), .poolEmpty(poolEmpty),
    .frameDone(frameDone), .remoteAck(remoteAck),
    .readyPulse(readyPulse), .cmdError(cmdError)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then settle at the next falling edge
  task automatic drive(input logic v, input logic [1:0] t, input logic e,
                       input logic a, input logic pe, input logic fd,
                       input logic ra);
    cmdValid = v; cmdType = t; cmdEnd = e; autoMode = a;
    poolEmpty = pe; frameDone = fd; remoteAck = ra;
    @(negedge clk);
    cmdValid = 0; cmdType = 0; cmdEnd = 0; autoMode = 0;
    poolEmpty = 0; frameDone = 0; remoteAck = 0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 ready after reset", readyPulse, 1'b0);
    check("R1 error after reset", cmdError, 1'b0);
    drive(0, 2'b00, 0, 0, 1, 0, 0);
    check("R1 no pending after reset", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 0, 1, 1);
    check("R11 idle events ignored", readyPulse, 1'b0);
  endtask

  task automatic testNoEnd();
    drive(1, 2'b01, 0, 0, 0, 0, 0);
    check("R3 no pulse at accept", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 1, 0, 0);
    check("R3 pool drained pulse", readyPulse, 1'b1);
    drive(0, 2'b00, 0, 0, 1, 0, 0);
    check("R8 pulse one cycle then idle", readyPulse, 1'b0);
  endtask

  task automatic testPoolWithFrame();
    drive(1, 2'b10, 0, 1, 0, 0, 0);
    drive(0, 2'b00, 0, 0, 1, 1, 0);
    check("R4 drain with frame end ignored", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 1, 0, 0);
    check("R4 later drain completes", readyPulse, 1'b1);
    drive(0, 2'b00, 0, 0, 0, 0, 0);
  endtask

  task automatic testTransEnd();
    drive(1, 2'b01, 1, 1, 0, 0, 0);
    drive(0, 2'b00, 0, 0, 1, 0, 0);
    check("R5 drain ignored", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 0, 0, 1);
    check("R5 ack ignored", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 0, 1, 0);
    check("R5 frame end pulse", readyPulse, 1'b1);
    drive(0, 2'b00, 0, 0, 0, 0, 0);
  endtask

  task automatic testInfoAuto();
    // ack first
    drive(1, 2'b10, 1, 1, 0, 0, 0);
    drive(0, 2'b00, 0, 0, 0, 0, 1);
    check("R6 ack alone no pulse", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 1, 0, 0);
    check("R6 drain no pulse", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 0, 1, 0);
    check("R6 ack then frame pulse", readyPulse, 1'b1);
    // frame first
    drive(1, 2'b10, 1, 1, 0, 0, 0);
    check("R8 pulse ended", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 0, 1, 0);
    check("R6 frame alone no pulse", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 0, 0, 0);
    check("R6 still waiting", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 0, 0, 1);
    check("R6 frame then ack pulse", readyPulse, 1'b1);
    // same cycle
    drive(1, 2'b10, 1, 1, 0, 0, 0);
    drive(0, 2'b00, 0, 0, 0, 1, 1);
    check("R6 both together pulse", readyPulse, 1'b1);
    drive(0, 2'b00, 0, 0, 0, 0, 0);
  endtask

  task automatic testInfoNoAuto();
    drive(1, 2'b10, 1, 0, 0, 0, 0);
    drive(0, 2'b00, 0, 1, 0, 1, 0);
    check("R7 frame end alone completes", readyPulse, 1'b1);
    drive(0, 2'b00, 0, 0, 0, 0, 0);
  endtask

  task automatic testInvalid();
    drive(1, 2'b00, 0, 0, 0, 0, 0);
    drive(0, 2'b00, 0, 0, 1, 0, 0);
    check("R2 code 00 ignored", readyPulse, 1'b0);
    drive(1, 2'b11, 1, 0, 0, 0, 0);
    drive(0, 2'b00, 0, 0, 0, 1, 0);
    check("R2 code 11 ignored", readyPulse, 1'b0);
    check("R2 no error on bad code", cmdError, 1'b0);
  endtask

  task automatic testReject();
    drive(1, 2'b01, 1, 0, 0, 0, 0);
    drive(1, 2'b01, 0, 0, 0, 0, 0);
    check("R9 error raised", cmdError, 1'b1);
    drive(0, 2'b00, 0, 0, 1, 0, 0);
    check("R9 pending unchanged", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 0, 1, 0);
    check("R9 original completes", readyPulse, 1'b1);
    drive(0, 2'b00, 0, 0, 0, 0, 0);
    check("R9 error sticky", cmdError, 1'b1);
    doReset();
    check("R12 reset clears error", cmdError, 1'b0);
  endtask

  task automatic testResetPending();
    drive(1, 2'b01, 0, 0, 0, 0, 0);
    doReset();
    drive(0, 2'b00, 0, 0, 1, 0, 0);
    check("R12 reset drops pending", readyPulse, 1'b0);
  endtask

  task automatic testSameCycle();
    drive(1, 2'b01, 0, 0, 0, 0, 0);
    drive(1, 2'b01, 1, 0, 1, 0, 0);
    check("R10 completion pulse", readyPulse, 1'b1);
    check("R10 no error", cmdError, 1'b0);
    drive(0, 2'b00, 0, 0, 1, 0, 0);
    check("R10 new cmd ignores drain", readyPulse, 1'b0);
    drive(0, 2'b00, 0, 0, 0, 1, 0);
    check("R10 new cmd completes", readyPulse, 1'b1);
    drive(0, 2'b00, 0, 0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testNoEnd();
    testPoolWithFrame();
    testTransEnd();
    testInfoAuto();
    testInfoNoAuto();
    testInvalid();
    testReject();
    testResetPending();
    testSameCycle();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule